// File: doc/BRIEF.md
# Pipelined Argmax Tree

This block receives a set of equal-width channel values side by side on one wide bus. It reports which channel holds the largest value, and what that value is. A typical use is locating the hottest sensor among many, where a downstream stage needs both the peak amplitude and its position. The channel count is a power of two, set by the number of tree levels.

The values pass through a binary tree of two-input comparators, with a register after every level. Each node forwards the larger of its two operands together with that operand's partial index. The decision taken at level k becomes index bit k, so the full channel number is assembled by the time the result leaves the last level. A valid flag travels alongside the data with the same delay. A new vector can be presented on every clock edge and there is never a stall.

Top module: `argmax_tree`

## Requirements
- R1: When `out_valid` is high, `out_max` equals the largest of the channel values that were presented with `in_valid` exactly LEVELS clock cycles earlier.
- R2: Channel c occupies bits `[c*VAL_W +: VAL_W]` of `in_vals`. `out_idx` gives the number of a channel whose value equals `out_max`. Bit k of `out_idx` is the decision of tree level k, so bit 0 separates even-numbered from odd-numbered channels.
- R3: When several channels share the maximum value, `out_idx` reports the lowest-numbered of them. When all channels are equal, it reports 0.
- R4: `out_valid` is `in_valid` delayed by exactly LEVELS clock cycles. Idle cycles in the input produce idle cycles at the output in the same positions.
- R5: A new vector is accepted on every clock. Back-to-back vectors yield back-to-back results in the same order, with none lost or merged.
- R6: `rst` is synchronous and active high. While it is asserted, and on the first cycle after it is released, `out_valid` is low. After release, `out_valid` stays low until a valid vector has had LEVELS cycles to pass through the tree.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Marks `in_vals` as carrying a vector this cycle |
| in_vals | input | (2**LEVELS)*VAL_W | All channel values; channel c at `[c*VAL_W +: VAL_W]` |
| out_valid | output | 1 | Result on `out_max`/`out_idx` is meaningful |
| out_max | output | VAL_W | Largest channel value of the vector |
| out_idx | output | LEVELS | Lowest channel number holding `out_max` |

## Verification
The first pattern places a single dominant value at each channel in turn. This tells apart a correct index from one that has its bits swapped or misses a level's decision. Further vectors hold only one nonzero channel, at positions such as 1, 2 and 8, to pin down individual index bits. All-equal vectors and vectors with two equal maxima probe the tie rule in three positions: within one node pair, across sub-trees, and at the two extreme channels. A wrong comparison operator would pick the higher-numbered channel in these cases. Long back-to-back random streams, and streams with valid gaps, separate correct per-cycle throughput and valid alignment from results that are shifted, dropped or duplicated.

// File: rtl/argmax_pkg.sv
package argmax_pkg;
  localparam int DEF_VAL_W  = 8;
  localparam int DEF_LEVELS = 4;

  function automatic int chan_count(input int levels);
    return 1 << levels;
  endfunction
endpackage

// File: rtl/argmax_node.sv
module argmax_node #(
  parameter int VAL_W = 8,
  parameter int IDX_W = 4,
  parameter int BIT   = 0
) (
  input  logic             clk,
  input  logic [VAL_W-1:0] a_val,
  input  logic [IDX_W-1:0] a_idx,
  input  logic [VAL_W-1:0] b_val,
  input  logic [IDX_W-1:0] b_idx,
  output logic [VAL_W-1:0] q_val,
  output logic [IDX_W-1:0] q_idx
);
  logic             b_wins;
  logic [IDX_W-1:0] win_idx;

  // strict greater-than: on equality operand A (lower channel) is kept
  assign b_wins  = (b_val > a_val);
  assign win_idx = b_wins ? b_idx : a_idx;

  always_ff @(posedge clk) begin
    q_val <= b_wins ? b_val : a_val;
    q_idx <= win_idx | (IDX_W'(b_wins) << BIT);
  end
endmodule

// File: rtl/argmax_level.sv
module argmax_level #(
  parameter int VAL_W = 8,
  parameter int IDX_W = 4,
  parameter int LVL   = 0,
  parameter int N_OUT = 8
) (
  input  logic                     clk,
  input  logic [2*N_OUT*VAL_W-1:0] in_val,
  input  logic [2*N_OUT*IDX_W-1:0] in_idx,
  output logic [N_OUT*VAL_W-1:0]   out_val,
  output logic [N_OUT*IDX_W-1:0]   out_idx
);
  for (genvar j = 0; j < N_OUT; j++) begin : g_node
    argmax_node #(.VAL_W(VAL_W), .IDX_W(IDX_W), .BIT(LVL)) u_node (
      .clk   (clk),
      .a_val (in_val[(2*j)*VAL_W +: VAL_W]),
      .a_idx (in_idx[(2*j)*IDX_W +: IDX_W]),
      .b_val (in_val[(2*j+1)*VAL_W +: VAL_W]),
      .b_idx (in_idx[(2*j+1)*IDX_W +: IDX_W]),
      .q_val (out_val[j*VAL_W +: VAL_W]),
      .q_idx (out_idx[j*IDX_W +: IDX_W])
    );
  end
endmodule

// File: rtl/argmax_vpipe.sv
module argmax_vpipe #(
  parameter int DEPTH = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [DEPTH-1:0] stage;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage <= '0;
    end else begin
      stage[0] <= d;
      for (int i = 1; i < DEPTH; i++) stage[i] <= stage[i-1];
    end
  end

  assign q = stage[DEPTH-1];
endmodule

// File: rtl/argmax_tree.sv
module argmax_tree
  import argmax_pkg::*;
#(
  parameter int VAL_W  = DEF_VAL_W,
  parameter int LEVELS = DEF_LEVELS
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  in_valid,
  input  logic [chan_count(LEVELS)*VAL_W-1:0]   in_vals,
  output logic                                  out_valid,
  output logic [VAL_W-1:0]                      out_max,
  output logic [LEVELS-1:0]                     out_idx
);
  localparam int N = chan_count(LEVELS);

  for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
    localparam int NI = N >> l;
    localparam int NO = NI / 2;
    logic [NI*VAL_W-1:0]  i_val;
    logic [NI*LEVELS-1:0] i_idx;
    logic [NO*VAL_W-1:0]  o_val;
    logic [NO*LEVELS-1:0] o_idx;

    if (l == 0) begin : g_src
      assign i_val = in_vals;
      assign i_idx = '0;
    end else begin : g_src
      assign i_val = g_lvl[l-1].o_val;
      assign i_idx = g_lvl[l-1].o_idx;
    end

    argmax_level #(.VAL_W(VAL_W), .IDX_W(LEVELS), .LVL(l), .N_OUT(NO)) u_level (
      .clk     (clk),
      .in_val  (i_val),
      .in_idx  (i_idx),
      .out_val (o_val),
      .out_idx (o_idx)
    );
  end

  argmax_vpipe #(.DEPTH(LEVELS)) u_vpipe (
    .clk (clk),
    .rst (rst),
    .d   (in_valid),
    .q   (out_valid)
  );

  assign out_max = g_lvl[LEVELS-1].o_val;
  assign out_idx = g_lvl[LEVELS-1].o_idx;
endmodule

// File: rtl/argmax_tree_chk.sv
module argmax_tree_chk #(
  parameter int VAL_W  = 8,
  parameter int LEVELS = 4
) (
  input logic                              clk,
  input logic                              rst,
  input logic                              in_valid,
  input logic [(1<<LEVELS)*VAL_W-1:0]      in_vals,
  input logic                              out_valid,
  input logic [VAL_W-1:0]                  out_max,
  input logic [LEVELS-1:0]                 out_idx
);
  localparam int N     = 1 << LEVELS;
  localparam int BUS_W = N * VAL_W;

  logic [LEVELS-1:0] v_hist;
  logic [BUS_W-1:0]  d_hist [LEVELS];
  logic              ok_ge, ok_hit, ok_low;

  always_ff @(posedge clk) begin
    if (rst) begin
      v_hist <= '0;
    end else begin
      v_hist[0] <= in_valid;
      for (int i = 1; i < LEVELS; i++) v_hist[i] <= v_hist[i-1];
    end
    d_hist[0] <= in_vals;
    for (int i = 1; i < LEVELS; i++) d_hist[i] <= d_hist[i-1];
  end

  always_comb begin
    ok_ge  = 1'b1;
    ok_hit = 1'b0;
    ok_low = 1'b1;
    for (int c = 0; c < N; c++) begin
      if (d_hist[LEVELS-1][c*VAL_W +: VAL_W] > out_max) ok_ge = 1'b0;
      if (c == int'(out_idx) && d_hist[LEVELS-1][c*VAL_W +: VAL_W] == out_max) ok_hit = 1'b1;
      if (c < int'(out_idx) && d_hist[LEVELS-1][c*VAL_W +: VAL_W] == out_max) ok_low = 1'b0;
    end
  end

  a_r4_valid_delay: assert property (@(posedge clk) disable iff (rst)
    out_valid == v_hist[LEVELS-1]);
  a_r1_max_bound: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ok_ge);
  a_r2_idx_holds_max: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ok_hit);
  a_r3_lowest_on_tie: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ok_low);
  a_r6_clear_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_valid);
endmodule

bind argmax_tree argmax_tree_chk #(.VAL_W(VAL_W), .LEVELS(LEVELS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_vals   (in_vals),
  .out_valid (out_valid),
  .out_max   (out_max),
  .out_idx   (out_idx)
);

// File: tb/argmax_tree_bench.sv
module argmax_tree_bench;
  localparam int VW    = 8;
  localparam int L     = 4;
  localparam int N     = 1 << L;
  localparam int BUS_W = N * VW;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             in_valid = 1'b0;
  logic [BUS_W-1:0] in_vals = '0;
  logic             out_valid;
  logic [VW-1:0]    out_max;
  logic [L-1:0]     out_idx;

  int checks = 0;
  int errors = 0;
  logic [BUS_W-1:0] vecs [0:63];
  logic             vvs  [0:63];
  int               nvec;
  string            idx_tag;

  always #10 clk = ~clk;

  argmax_tree #(.VAL_W(VW), .LEVELS(L)) u_argmax_tree (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_vals(in_vals),
    .out_valid(out_valid), .out_max(out_max), .out_idx(out_idx)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_out(input int j);
    int bv, bi;
    chk(out_valid == vvs[j], "R4 valid", int'(out_valid), int'(vvs[j]));
    if (vvs[j]) begin
      bv = -1; bi = 0;
      for (int c = 0; c < N; c++)
        if (int'(vecs[j][c*VW +: VW]) > bv) begin bv = int'(vecs[j][c*VW +: VW]); bi = c; end
      chk(int'(out_max) == bv, "R1 max", int'(out_max), bv);
      chk(int'(out_idx) == bi, idx_tag, int'(out_idx), bi);
    end
  endtask

  task automatic run_stream();
    for (int k = 0; k < nvec + L; k++) begin
      @(negedge clk);
      if (k >= L) check_out(k - L);
      if (k < nvec) begin
        in_vals  = vecs[k];
        in_valid = vvs[k];
      end else begin
        in_vals  = '0;
        in_valid = 1'b0;
      end
    end
  endtask

  function automatic logic [BUS_W-1:0] rand_vec(input int lim);
    logic [BUS_W-1:0] v;
    for (int c = 0; c < N; c++) v[c*VW +: VW] = VW'($urandom_range(lim, 0));
    return v;
  endfunction

  task automatic test_reset();
    rst = 1'b1; in_valid = 1'b1; in_vals = rand_vec(255);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0, "R6 during reset", int'(out_valid), 0);
    rst = 1'b0; in_valid = 1'b0;
    for (int k = 0; k < L + 1; k++) begin
      @(negedge clk);
      chk(out_valid == 1'b0, "R6 after reset", int'(out_valid), 0);
    end
  endtask

  task automatic test_walking_peak();
    idx_tag = "R2 walking";
    nvec = N;
    for (int c = 0; c < N; c++) begin
      vecs[c] = rand_vec(99);
      vecs[c][c*VW +: VW] = VW'(150 + c);
      vvs[c] = 1'b1;
    end
    run_stream();
  endtask

  task automatic test_index_bits();
    idx_tag = "R2 index bit";
    nvec = 4;
    vecs[0] = '0; vecs[0][1*VW +: VW] = 8'd5;
    vecs[1] = '0; vecs[1][2*VW +: VW] = 8'd9;
    vecs[2] = '0; vecs[2][8*VW +: VW] = 8'd1;
    vecs[3] = '0; vecs[3][(N-1)*VW +: VW] = 8'd255;
    for (int i = 0; i < 4; i++) vvs[i] = 1'b1;
    run_stream();
  endtask

  task automatic test_ties();
    idx_tag = "R3 tie";
    nvec = 6;
    for (int i = 0; i < 3; i++) begin
      vecs[i] = {N{VW'(8'd0 + 8'(i * 77))}};
      vvs[i] = 1'b1;
    end
    vecs[3] = rand_vec(100); vecs[3][4*VW +: VW] = 8'd200; vecs[3][5*VW +: VW] = 8'd200;
    vecs[4] = rand_vec(100); vecs[4][3*VW +: VW] = 8'd180; vecs[4][12*VW +: VW] = 8'd180;
    vecs[5] = rand_vec(100); vecs[5][0 +: VW] = 8'd255; vecs[5][(N-1)*VW +: VW] = 8'd255;
    for (int i = 3; i < 6; i++) vvs[i] = 1'b1;
    run_stream();
  endtask

  task automatic test_random_stream();
    idx_tag = "R5 stream";
    nvec = 40;
    for (int i = 0; i < nvec; i++) begin
      vecs[i] = rand_vec((i % 2 == 0) ? 255 : 7);
      vvs[i] = 1'b1;
    end
    run_stream();
  endtask

  task automatic test_valid_gaps();
    idx_tag = "R4 gaps";
    nvec = 20;
    for (int i = 0; i < nvec; i++) begin
      vecs[i] = rand_vec(255);
      vvs[i] = ((i % 3) != 1);
    end
    run_stream();
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    test_reset();
    test_walking_peak();
    test_index_bits();
    test_ties();
    test_random_stream();
    test_valid_gaps();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule